// File: doc/BRIEF.md
# Microcode Breakpoint and Halt Controller

This block sits beside a microcode sequencer and decides when that sequencer must stop. It watches the retired-instruction stream, presented as a 64-bit program counter with a valid strobe. It collects break sources into a 16-bit pending event word: instruction-breakpoint pulses from an external opcode matcher, two address comparators, a single-step counter, an external break request, an ordering-mode change and any other raw event bits.

While running, the block services at most one pending event per clock, in a fixed priority order. An ordering-mode change is absorbed and execution continues. A terminal event moves the block into a halted state with a reason code, and a stall output is held high there. A resume pulse leaves the halted state. Any event the block does not understand, and an external break that arrives while external break is not armed, both lead to a fatal locked state. Only reset leaves the fatal state. Software programs the block through a small word-addressed register port.

Register map (word address on `reg_addr`): 0 control, 1 step count, 2/3 comparator 0 low/high half, 4/5 comparator 1 low/high half, 6 ordering (bit 1 = requested mode), 7 halt control (bit 0 = external break armed). Control bits: 0 instruction-break pulse enable, 1 table-sourced break enable, 2 forced-pause enable, 3 step mode, 4/5 comparator 0/1 valid, 6/7 instruction-counter 0/1 valid, 8 immediate pause request.

Top module: `uhc_halt_ctrl`

## Requirements
- R1: After a synchronous active-low reset, stall, halted, fatal, halt_reason, fatal_word and order_mode are 0. The control register reads 0x007 and every other register reads 0.
- R2: A pulse on ibrk_evt (gated by control bit 0), pbrk_evt (bit 1), icnt_evt[0] (bit 6) or icnt_evt[1] (bit 7) sets pending bit 2. This halts the block with reason 4 on the second rising edge after the pulse. A pulse whose enable bit is clear has no effect.
- R3: A retired PC equal to the full 64-bit value of a comparator whose valid bit (control bit 4 or 5) is set raises pending bit 2 and halts with reason 4. A match only on the low 32-bit half does nothing.
- R4: With control bit 3 set, the step register counts down once per retired instruction while the block is not stalled. The step that brings it from 1 to 0 raises pending bit 8, which halts with reason 64. The remaining count can be read at address 1.
- R5: An external break (pending bit 3) with halt-control bit 0 set halts with reason 8 and clears that bit. If the bit is clear, the block enters the fatal state instead.
- R6: When several handled bits are pending at once, they are serviced in the order bit 9, bit 2, bit 3, bit 8, one per clock while running. Each later one is taken after the previous halt is resumed.
- R7: A write to ordering bit 1 that changes its value raises pending bit 9. Servicing bit 9 copies the requested mode to order_mode without stalling. A write of the same value raises nothing.
- R8: Setting control bit 8 while control bit 2 is set halts with reason 1 once no event is pending, and the hardware clears bit 8. With bit 2 clear, bit 8 has no effect.
- R9: A pending bit outside {2, 3, 8, 9}, seen when none of those bits is pending, enters the fatal state. In that state stall and fatal are high and fatal_word holds the pending word. Resume is ignored and only reset clears the state.
- R10: While halted, stall stays high and halt_reason stays constant. A resume pulse clears the serviced pending bit, drops stall and returns halt_reason to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| retire_valid | input | 1 | A microcode instruction retired this cycle |
| retire_pc | input | 64 | PC of the retired instruction |
| ibrk_evt | input | 1 | Instruction-breakpoint pulse from the opcode matcher |
| pbrk_evt | input | 1 | Table-sourced breakpoint pulse |
| icnt_evt | input | 2 | Instruction-counter threshold pulses |
| ext_brk_evt | input | 1 | External break request pulse |
| raw_evt | input | 16 | Other event bits merged into the pending word |
| resume | input | 1 | Leave the halted state |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| stall | output | 1 | Sequencer must stop (halted or fatal) |
| halted | output | 1 | Halted state, resumable |
| halt_reason | output | 8 | Reason code while halted |
| fatal | output | 1 | Fatal locked state |
| fatal_word | output | 16 | Pending word captured on entering the fatal state |
| order_mode | output | 1 | Ordering mode currently applied |

## Verification
The hardest situation to reach is several handled events pending in the same cycle, because each source has its own path and latency. The bench gets there by arming the external break and loading a step count of one. It then drives, in a single cycle, an instruction-break pulse, an external break, the final retirement and an ordering-register toggle. This sets bits 9, 8, 3 and 2 together, and the bench follows the ordering update and then three halts, checking each reason in turn. A behavioural reference model, advanced on every clock, covers all other interleavings of the directed stimulus.

// File: rtl/uhc_pkg.sv
// Package: shared constants and types for the microcode halt controller.
// Assumes a 64-bit microcode PC split into two 32-bit register halves.
package uhc_pkg;
    localparam int PC_W     = 64;
    localparam int STEP_W   = 32;
    localparam int EV_W     = 16;
    localparam int RSN_W    = 8;
    localparam int NUM_ACMP = 2;
    localparam int CTRL_W   = 9;

    // pending-event bit positions (priority order: ORD, INS, EXT, STEP)
    localparam int EV_INS  = 2;
    localparam int EV_EXT  = 3;
    localparam int EV_STEP = 8;
    localparam int EV_ORD  = 9;

    // halt reason codes
    localparam logic [RSN_W-1:0] RSN_PAUSE = 8'd1;
    localparam logic [RSN_W-1:0] RSN_INS   = 8'd4;
    localparam logic [RSN_W-1:0] RSN_EXT   = 8'd8;
    localparam logic [RSN_W-1:0] RSN_STEP  = 8'd64;

    // control register bit positions
    localparam int CB_IBRK  = 0;
    localparam int CB_PBRK  = 1;
    localparam int CB_PAUSE = 2;
    localparam int CB_STEP  = 3;
    localparam int CB_ACMP0 = 4;
    localparam int CB_ICNT0 = 6;
    localparam int CB_PREQ  = 8;
    localparam logic [CTRL_W-1:0] CTRL_RST = 9'h007;

    // register word addresses
    localparam int RA_CTRL  = 0;
    localparam int RA_STEP  = 1;
    localparam int RA_ACMP0 = 2;
    localparam int RA_ORDER = RA_ACMP0 + 2 * NUM_ACMP;
    localparam int RA_HCTL  = RA_ORDER + 1;
    localparam int ADDR_W   = $clog2(RA_HCTL + 1);

    typedef enum logic [1:0] {ST_RUN = 2'd0, ST_HALT = 2'd1, ST_FATAL = 2'd2} hstate_t;
endpackage

// File: rtl/uhc_regs.sv
// Module: register file of the halt controller plus the step down-counter.
// Holds control, step count, comparator addresses, ordering request and the
// external-break arm bit. Hardware clears (pause request, arm) win over a
// software write in the same cycle. Assumes retire_ok is already qualified
// by "not stalled".
module uhc_regs
    import uhc_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           reg_wr,
    input  logic [ADDR_W-1:0]              reg_addr,
    input  logic [31:0]                    reg_wdata,
    input  logic                           retire_ok,
    input  logic                           clr_pause,
    input  logic                           clr_extarm,
    output logic [CTRL_W-1:0]              ctrl,
    output logic [NUM_ACMP-1:0][PC_W-1:0]  acmp_addr,
    output logic                           order_req,
    output logic                           ext_armed,
    output logic                           step_evt,
    output logic                           order_evt,
    output logic [31:0]                    reg_rdata
);
    logic [STEP_W-1:0] step_q;
    logic              wr_step;
    logic              step_dec;

    assign wr_step  = reg_wr && (reg_addr == ADDR_W'(RA_STEP));
    assign step_dec = retire_ok && ctrl[CB_STEP] && (step_q != '0);
    assign step_evt = step_dec && (step_q == STEP_W'(1)) && !wr_step;
    assign order_evt = reg_wr && (reg_addr == ADDR_W'(RA_ORDER)) && (reg_wdata[1] != order_req);

    // control register with hardware self-clear of the pause request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= CTRL_RST;
        end else begin
            if (reg_wr && reg_addr == ADDR_W'(RA_CTRL)) ctrl <= reg_wdata[CTRL_W-1:0];
            if (clr_pause) ctrl[CB_PREQ] <= 1'b0;
        end
    end

    // step counter: software load wins over the per-retire decrement
    always_ff @(posedge clk) begin
        if (!rst_n)        step_q <= '0;
        else if (wr_step)  step_q <= reg_wdata[STEP_W-1:0];
        else if (step_dec) step_q <= step_q - STEP_W'(1);
    end

    // ordering request and external-break arm bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            order_req <= 1'b0;
            ext_armed <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == ADDR_W'(RA_ORDER)) order_req <= reg_wdata[1];
            if (reg_wr && reg_addr == ADDR_W'(RA_HCTL))  ext_armed <= reg_wdata[0];
            if (clr_extarm) ext_armed <= 1'b0;
        end
    end

    // one comparator address per generate instance, written as two halves
    for (genvar g = 0; g < NUM_ACMP; g++) begin : g_acmp
        localparam int LO = RA_ACMP0 + 2 * g;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acmp_addr[g] <= '0;
            end else if (reg_wr) begin
                if (reg_addr == ADDR_W'(LO))     acmp_addr[g][31:0]  <= reg_wdata;
                if (reg_addr == ADDR_W'(LO + 1)) acmp_addr[g][63:32] <= reg_wdata;
            end
        end
    end

    // read multiplexer
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(RA_CTRL))  reg_rdata = {{(32-CTRL_W){1'b0}}, ctrl};
        if (reg_addr == ADDR_W'(RA_STEP))  reg_rdata = step_q;
        if (reg_addr == ADDR_W'(RA_ORDER)) reg_rdata = {30'b0, order_req, 1'b0};
        if (reg_addr == ADDR_W'(RA_HCTL))  reg_rdata = {31'b0, ext_armed};
        for (int g = 0; g < NUM_ACMP; g++) begin
            if (reg_addr == ADDR_W'(RA_ACMP0 + 2 * g))     reg_rdata = acmp_addr[g][31:0];
            if (reg_addr == ADDR_W'(RA_ACMP0 + 2 * g + 1)) reg_rdata = acmp_addr[g][63:32];
        end
    end
endmodule

// File: rtl/uhc_collect.sv
// Module: merges all break sources into one per-cycle event vector.
// Instruction-break pulses are gated by their enables; address matches
// count only for retirements that happen while the sequencer runs.
module uhc_collect
    import uhc_pkg::*;
(
    input  logic                           retire_ok,
    input  logic [PC_W-1:0]                retire_pc,
    input  logic [NUM_ACMP-1:0][PC_W-1:0]  acmp_addr,
    input  logic [NUM_ACMP-1:0]            acmp_valid,
    input  logic [1:0]                     ibrk_en,
    input  logic [1:0]                     icnt_en,
    input  logic                           ibrk_evt,
    input  logic                           pbrk_evt,
    input  logic [1:0]                     icnt_evt,
    input  logic                           ext_brk_evt,
    input  logic                           step_evt,
    input  logic                           order_evt,
    input  logic [EV_W-1:0]                raw_evt,
    output logic [EV_W-1:0]                new_ev
);
    logic [NUM_ACMP-1:0] acmp_hit;
    logic                ins_any;

    // one full-width comparator per address register
    for (genvar g = 0; g < NUM_ACMP; g++) begin : g_cmp
        assign acmp_hit[g] = retire_ok && acmp_valid[g] && (retire_pc == acmp_addr[g]);
    end

    assign ins_any = (ibrk_evt && ibrk_en[0]) || (pbrk_evt && ibrk_en[1])
                   || |(icnt_evt & icnt_en) || |acmp_hit;

    // assemble the event vector in pending-word bit positions
    always_comb begin
        new_ev          = raw_evt;
        new_ev[EV_INS]  = raw_evt[EV_INS]  | ins_any;
        new_ev[EV_EXT]  = raw_evt[EV_EXT]  | ext_brk_evt;
        new_ev[EV_STEP] = raw_evt[EV_STEP] | step_evt;
        new_ev[EV_ORD]  = raw_evt[EV_ORD]  | order_evt;
    end
endmodule

// File: rtl/uhc_dispatch.sv
// Module: pending-event word and run/halt/fatal state machine.
// Services at most one pending bit per clock while running, in the fixed
// order ORD, INS, EXT, STEP; a forced pause is taken only when nothing is
// pending. Assumes new_ev is valid every cycle.
module uhc_dispatch
    import uhc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EV_W-1:0]  new_ev,
    input  logic             pause_req,
    input  logic             ext_armed,
    input  logic             order_req,
    input  logic             resume,
    output logic             stall,
    output logic             halted,
    output logic [RSN_W-1:0] halt_reason,
    output logic             fatal,
    output logic [EV_W-1:0]  fatal_word,
    output logic             order_mode,
    output logic             clr_pause,
    output logic             clr_extarm
);
    hstate_t          st_q, st_d;
    logic [EV_W-1:0]  pend_q, serv_q, serv_d, fw_d, clr;
    logic [RSN_W-1:0] rsn_d;
    logic             om_d;

    // next-state decision for one service pass
    always_comb begin
        st_d = st_q; rsn_d = halt_reason; serv_d = serv_q;
        fw_d = fatal_word; om_d = order_mode; clr = '0;
        clr_pause = 1'b0; clr_extarm = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                if (pend_q[EV_ORD]) begin
                    clr[EV_ORD] = 1'b1;
                    om_d = order_req;
                end else if (pend_q[EV_INS]) begin
                    st_d = ST_HALT; rsn_d = RSN_INS; serv_d = EV_W'(1) << EV_INS;
                end else if (pend_q[EV_EXT]) begin
                    if (ext_armed) begin
                        st_d = ST_HALT; rsn_d = RSN_EXT; serv_d = EV_W'(1) << EV_EXT;
                        clr_extarm = 1'b1;
                    end else begin
                        st_d = ST_FATAL; fw_d = pend_q;
                    end
                end else if (pend_q[EV_STEP]) begin
                    st_d = ST_HALT; rsn_d = RSN_STEP; serv_d = EV_W'(1) << EV_STEP;
                end else if (pend_q != '0) begin
                    st_d = ST_FATAL; fw_d = pend_q;
                end else if (pause_req) begin
                    st_d = ST_HALT; rsn_d = RSN_PAUSE; serv_d = '0;
                    clr_pause = 1'b1;
                end
            end
            ST_HALT: begin
                if (resume) begin
                    st_d = ST_RUN; rsn_d = '0; clr = serv_q;
                end
            end
            default: ;
        endcase
    end

    // state, pending word and captured outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_RUN; pend_q <= '0; serv_q <= '0;
            halt_reason <= '0; fatal_word <= '0; order_mode <= 1'b0;
        end else begin
            st_q <= st_d; pend_q <= (pend_q & ~clr) | new_ev; serv_q <= serv_d;
            halt_reason <= rsn_d; fatal_word <= fw_d; order_mode <= om_d;
        end
    end

    assign halted = (st_q == ST_HALT);
    assign fatal  = (st_q == ST_FATAL);
    assign stall  = halted || fatal;
endmodule

// File: rtl/uhc_halt_ctrl.sv
// Module: top of the microcode breakpoint and halt controller.
// Wires the register file, the event collector and the dispatcher. Assumes
// the sequencer honours stall in the same cycle it is seen.
module uhc_halt_ctrl
    import uhc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              retire_valid,
    input  logic [PC_W-1:0]   retire_pc,
    input  logic              ibrk_evt,
    input  logic              pbrk_evt,
    input  logic [1:0]        icnt_evt,
    input  logic              ext_brk_evt,
    input  logic [EV_W-1:0]   raw_evt,
    input  logic              resume,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              stall,
    output logic              halted,
    output logic [RSN_W-1:0]  halt_reason,
    output logic              fatal,
    output logic [EV_W-1:0]   fatal_word,
    output logic              order_mode
);
    logic [CTRL_W-1:0]             ctrl;
    logic [NUM_ACMP-1:0][PC_W-1:0] acmp_addr;
    logic [EV_W-1:0]               new_ev;
    logic order_req, ext_armed, step_evt, order_evt, clr_pause, clr_extarm, retire_ok;

    assign retire_ok = retire_valid && !stall;

    uhc_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .retire_ok(retire_ok), .clr_pause(clr_pause),
        .clr_extarm(clr_extarm), .ctrl(ctrl), .acmp_addr(acmp_addr),
        .order_req(order_req), .ext_armed(ext_armed), .step_evt(step_evt),
        .order_evt(order_evt), .reg_rdata(reg_rdata)
    );

    uhc_collect u_collect (
        .retire_ok(retire_ok), .retire_pc(retire_pc), .acmp_addr(acmp_addr),
        .acmp_valid(ctrl[CB_ACMP0 +: NUM_ACMP]), .ibrk_en(ctrl[CB_PBRK:CB_IBRK]),
        .icnt_en(ctrl[CB_ICNT0 +: 2]), .ibrk_evt(ibrk_evt), .pbrk_evt(pbrk_evt),
        .icnt_evt(icnt_evt), .ext_brk_evt(ext_brk_evt), .step_evt(step_evt),
        .order_evt(order_evt), .raw_evt(raw_evt), .new_ev(new_ev)
    );

    uhc_dispatch u_dispatch (
        .clk(clk), .rst_n(rst_n), .new_ev(new_ev),
        .pause_req(ctrl[CB_PREQ] && ctrl[CB_PAUSE]), .ext_armed(ext_armed),
        .order_req(order_req), .resume(resume), .stall(stall), .halted(halted),
        .halt_reason(halt_reason), .fatal(fatal), .fatal_word(fatal_word),
        .order_mode(order_mode), .clr_pause(clr_pause), .clr_extarm(clr_extarm)
    );
endmodule

// File: rtl/uhc_halt_ctrl_chk.sv
// Checker: temporal properties of the halt controller outputs, bound to the top.
module uhc_halt_ctrl_chk
    import uhc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             resume,
    input logic             stall,
    input logic             halted,
    input logic [RSN_W-1:0] halt_reason,
    input logic             fatal,
    input logic [EV_W-1:0]  fatal_word,
    input logic             order_mode
);
    AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |=> fatal && stall);                                                   // R9
    AST_FATAL_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        fatal && $past(fatal) |-> $stable(fatal_word));                              // R9
    AST_HALT_FATAL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(halted && fatal));                                                         // R9
    AST_REASON_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (halt_reason == RSN_PAUSE || halt_reason == RSN_INS ||
                    halt_reason == RSN_EXT || halt_reason == RSN_STEP));             // R10
    AST_REASON_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        halted && $past(halted) |-> $stable(halt_reason));                           // R10
    AST_RESUME_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        halted && resume |=> !stall && halt_reason == '0);                           // R10
    AST_ORDER_FROZEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        stall && $past(stall) |-> $stable(order_mode));                              // R7
endmodule

bind uhc_halt_ctrl uhc_halt_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .resume(resume), .stall(stall), .halted(halted),
    .halt_reason(halt_reason), .fatal(fatal), .fatal_word(fatal_word),
    .order_mode(order_mode)
);

// File: tb/uhc_halt_ctrl_bench.sv
// Bench: directed stimulus plus a behavioural reference model compared on every clock.
module uhc_halt_ctrl_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        retire_valid = 1'b0;
    logic [63:0] retire_pc = '0;
    logic        ibrk_evt = 1'b0, pbrk_evt = 1'b0, ext_brk_evt = 1'b0, resume = 1'b0;
    logic [1:0]  icnt_evt = '0;
    logic [15:0] raw_evt = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        stall, halted, fatal, order_mode;
    logic [7:0]  halt_reason;
    logic [15:0] fatal_word;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    uhc_halt_ctrl u_uhc_halt_ctrl (
        .clk(clk), .rst_n(rst_n), .retire_valid(retire_valid), .retire_pc(retire_pc),
        .ibrk_evt(ibrk_evt), .pbrk_evt(pbrk_evt), .icnt_evt(icnt_evt),
        .ext_brk_evt(ext_brk_evt), .raw_evt(raw_evt), .resume(resume),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .stall(stall), .halted(halted),
        .halt_reason(halt_reason), .fatal(fatal), .fatal_word(fatal_word),
        .order_mode(order_mode)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int          m_st;              // 0 run, 1 halted, 2 fatal
    logic [15:0] m_pend, m_serv, m_fw;
    logic [7:0]  m_rsn;
    logic        m_om, m_ord, m_arm;
    logic [8:0]  m_ctrl;
    logic [31:0] m_step;
    logic [63:0] m_a [2];

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return {23'b0, m_ctrl};
            3'd1: return m_step;
            3'd2: return m_a[0][31:0];
            3'd3: return m_a[0][63:32];
            3'd4: return m_a[1][31:0];
            3'd5: return m_a[1][63:32];
            3'd6: return {30'b0, m_ord, 1'b0};
            default: return {31'b0, m_arm};
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_pend = 0; m_serv = 0; m_fw = 0; m_rsn = 0; m_om = 0;
            m_ord = 0; m_arm = 0; m_ctrl = 9'h007; m_step = 0; m_a[0] = 0; m_a[1] = 0;
        end else begin
            logic [15:0] ev, clr;
            logic        ins, stp, ordev, wstep, clrp, clra;
            logic [31:0] step_n;
            ev = raw_evt; clr = 0; clrp = 0; clra = 0; stp = 0;
            ins = (ibrk_evt & m_ctrl[0]) | (pbrk_evt & m_ctrl[1]) |
                  (icnt_evt[0] & m_ctrl[6]) | (icnt_evt[1] & m_ctrl[7]);
            wstep = reg_wr && reg_addr == 3'd1;
            step_n = m_step;
            if (retire_valid && m_st == 0) begin
                for (int i = 0; i < 2; i++)
                    if (m_ctrl[4+i] && retire_pc == m_a[i]) ins = 1;
                if (m_ctrl[3] && m_step != 0) begin
                    step_n = m_step - 1;
                    if (m_step == 1 && !wstep) stp = 1;
                end
            end
            ordev = reg_wr && reg_addr == 3'd6 && reg_wdata[1] != m_ord;
            ev[2] |= ins; ev[3] |= ext_brk_evt; ev[8] |= stp; ev[9] |= ordev;
            if (m_st == 0) begin
                if (m_pend[9]) begin clr[9] = 1; m_om = m_ord; end
                else if (m_pend[2]) begin m_st = 1; m_rsn = 4; m_serv = 16'h0004; end
                else if (m_pend[3]) begin
                    if (m_arm) begin m_st = 1; m_rsn = 8; m_serv = 16'h0008; clra = 1; end
                    else begin m_st = 2; m_fw = m_pend; end
                end
                else if (m_pend[8]) begin m_st = 1; m_rsn = 64; m_serv = 16'h0100; end
                else if (m_pend != 0) begin m_st = 2; m_fw = m_pend; end
                else if (m_ctrl[8] && m_ctrl[2]) begin m_st = 1; m_rsn = 1; m_serv = 0; clrp = 1; end
            end else if (m_st == 1 && resume) begin
                clr = m_serv; m_st = 0; m_rsn = 0;
            end
            m_step = wstep ? reg_wdata : step_n;
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: m_ctrl = reg_wdata[8:0];
                    3'd2: m_a[0][31:0]  = reg_wdata;
                    3'd3: m_a[0][63:32] = reg_wdata;
                    3'd4: m_a[1][31:0]  = reg_wdata;
                    3'd5: m_a[1][63:32] = reg_wdata;
                    3'd6: m_ord = reg_wdata[1];
                    3'd7: m_arm = reg_wdata[0];
                    default: ;
                endcase
            end
            if (clrp) m_ctrl[8] = 0;
            if (clra) m_arm = 0;
            m_pend = (m_pend & ~clr) | ev;
        end
        #1;
        if (!done) begin
            chk("R10 model stall",  stall, m_st != 0);
            chk("R10 model halted", halted, m_st == 1);
            chk("R10 model reason", halt_reason, m_rsn);
            chk("R9 model fatal",   fatal, m_st == 2);
            chk("R9 model fatal_word", fatal_word, m_fw);
            chk("R7 model order_mode", order_mode, m_om);
            chk("R1 model reg_rdata", reg_rdata, m_read(reg_addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk); reg_addr = a; #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic retire(input logic [63:0] pc);
        @(negedge clk); retire_valid = 1; retire_pc = pc;
        @(negedge clk); retire_valid = 0;
    endtask

    task automatic do_resume();
        @(negedge clk); resume = 1;
        @(negedge clk); resume = 0;
        tick(1);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; tick(2); rst_n = 1; tick(1);
    endtask

    task automatic expect_halt(input string tag, input logic [7:0] rsn);
        chk({tag, " halted"}, halted, 1'b1);
        chk({tag, " reason"}, halt_reason, rsn);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1; checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(3); rst_n = 1; tick(1);
        // R1 reset state
        chk("R1 stall", stall, 0); chk("R1 reason", halt_reason, 0);
        chk("R1 order_mode", order_mode, 0);
        rd_chk("R1 ctrl reset", 3'd0, 32'h007);
        rd_chk("R1 step reset", 3'd1, 32'h0);

        // R2 instruction-break sources and gating
        @(negedge clk); ibrk_evt = 1; @(negedge clk); ibrk_evt = 0; tick(2);
        expect_halt("R2 ibrk", 8'd4);
        do_resume();
        chk("R10 stall after resume", stall, 0); chk("R10 reason cleared", halt_reason, 0);
        @(negedge clk); icnt_evt = 2'b01; @(negedge clk); icnt_evt = 0; tick(3);
        chk("R2 icnt0 disabled", stall, 0);
        wr(3'd0, 32'h047);
        @(negedge clk); icnt_evt = 2'b01; @(negedge clk); icnt_evt = 0; tick(2);
        expect_halt("R2 icnt0", 8'd4);
        do_resume();
        @(negedge clk); pbrk_evt = 1; @(negedge clk); pbrk_evt = 0; tick(2);
        expect_halt("R2 pbrk", 8'd4);
        do_resume();
        wr(3'd0, 32'h005);
        @(negedge clk); pbrk_evt = 1; @(negedge clk); pbrk_evt = 0; tick(3);
        chk("R2 pbrk disabled", stall, 0);
        wr(3'd0, 32'h006);
        @(negedge clk); ibrk_evt = 1; @(negedge clk); ibrk_evt = 0; tick(3);
        chk("R2 ibrk disabled", stall, 0);

        // R3 address comparator 0
        wr(3'd2, 32'h40); wr(3'd3, 32'h1); wr(3'd0, 32'h017);
        retire(64'h40); tick(3);
        chk("R3 low-half only", stall, 0);
        retire(64'h1_0000_0040); tick(2);
        expect_halt("R3 addr match", 8'd4);
        do_resume();
        wr(3'd0, 32'h007);

        // R4 single step
        wr(3'd1, 32'd3); wr(3'd0, 32'h00F);
        retire(64'h100); retire(64'h104); tick(1);
        chk("R4 not yet", stall, 0);
        rd_chk("R4 remaining", 3'd1, 32'd1);
        retire(64'h108); tick(2);
        expect_halt("R4 step", 8'd64);
        retire(64'h10C); tick(1);
        rd_chk("R4 stalled retire", 3'd1, 32'd0);
        do_resume();
        wr(3'd0, 32'h007);

        // R5 armed external break
        wr(3'd7, 32'h1);
        @(negedge clk); ext_brk_evt = 1; @(negedge clk); ext_brk_evt = 0; tick(2);
        expect_halt("R5 ext", 8'd8);
        rd_chk("R5 arm cleared", 3'd7, 32'h0);
        do_resume();

        // R6 priority with four handled bits pending together
        wr(3'd7, 32'h1); wr(3'd1, 32'd1); wr(3'd0, 32'h00F);
        @(negedge clk);
        ibrk_evt = 1; ext_brk_evt = 1; retire_valid = 1; retire_pc = 64'h999;
        reg_wr = 1; reg_addr = 3'd6; reg_wdata = 32'h2;
        @(negedge clk);
        ibrk_evt = 0; ext_brk_evt = 0; retire_valid = 0; reg_wr = 0;
        tick(2);
        expect_halt("R6 first ins", 8'd4);
        chk("R6 R7 order applied first", order_mode, 1);
        do_resume(); tick(1);
        expect_halt("R6 second ext", 8'd8);
        do_resume(); tick(1);
        expect_halt("R6 third step", 8'd64);
        do_resume(); tick(1);
        chk("R6 all serviced", stall, 0);
        wr(3'd0, 32'h007);

        // R7 ordering writes
        wr(3'd6, 32'h2); tick(3);
        chk("R7 same value", order_mode, 1); chk("R7 no stall", stall, 0);
        wr(3'd6, 32'h0); tick(3);
        chk("R7 toggle back", order_mode, 0); chk("R7 no stall 2", stall, 0);

        // R8 forced pause
        wr(3'd0, 32'h107); tick(2);
        expect_halt("R8 pause", 8'd1);
        rd_chk("R8 request self-clears", 3'd0, 32'h007);
        do_resume();
        wr(3'd0, 32'h103); tick(3);
        chk("R8 pause disabled", stall, 0);
        wr(3'd0, 32'h007);

        // R9 unhandled event
        @(negedge clk); raw_evt = 16'h0020; @(negedge clk); raw_evt = 0; tick(2);
        chk("R9 fatal", fatal, 1); chk("R9 word", fatal_word, 16'h0020);
        chk("R9 stall", stall, 1);
        do_resume(); tick(1);
        chk("R9 resume ignored", fatal, 1);
        do_reset();
        chk("R9 reset clears", fatal, 0); chk("R1 stall after reset", stall, 0);

        // R5 unarmed external break
        @(negedge clk); ext_brk_evt = 1; @(negedge clk); ext_brk_evt = 0; tick(2);
        chk("R5 unarmed fatal", fatal, 1); chk("R5 unarmed word", fatal_word, 16'h0008);
        do_reset();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule